// File: doc/BRIEF.md
# Damage rectangle queue

This block keeps a circular list of screen regions that have been redrawn and still have to be copied to the display. Drawing and command logic push rectangles (x, y, w, h) into it one per cycle. There is no full check, so a long burst of pushes overwrites the oldest pending regions. A later flush request drains the list in arrival order through a valid/ready output port, one rectangle per accepted beat.

Each rectangle is checked on its way out. The check uses fixed maximum dimensions and the current surface size. A rectangle that fails the check leaves the block as a full-surface update instead. An invalidate pulse marks the whole list as stale. The next flush then throws away everything pending rather than draining it, because a full redraw has been scheduled anyway.

Top module: `damage_rect_queue`

## Requirements
- R1: After reset the queue is empty, `flush_busy` is low and `out_valid` is low.
- R2: Every cycle with `push_valid` high stores one rectangle at the write position and advances it modulo DEPTH (default 512), with no full check. After DEPTH+k pushes without a flush, a flush delivers only the k newest rectangles.
- R3: A `flush_req` while idle, with entries pending and no invalidate pending, raises `flush_busy` on the next cycle. Rectangles then leave in push order, one per cycle in which `out_valid` and `out_ready` are both high.
- R4: `flush_busy` stays high until the queue is empty and falls one cycle after the last accepted rectangle. Rectangles pushed during a flush are drained by that same flush. `out_valid` is only ever high while `flush_busy` is high.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the presented rectangle does not change.
- R6: A rectangle is rejected in x when any of these holds: x < 0, x > MAX_W (2368), w < 0, w > MAX_W, or x+w > `surf_w`. A rectangle with x+w equal to `surf_w` is accepted.
- R7: A rectangle is rejected in y when any of these holds: y < 0, y > MAX_H (1770), h < 0, h > MAX_H, or y+h > `surf_h`. A rectangle with y+h equal to `surf_h` is accepted.
- R8: A rejected rectangle is presented as x=0, y=0, w=`surf_w`, h=`surf_h`. An accepted rectangle is presented unchanged.
- R9: An `invalidate` pulse sets a pending flag. The next accepted `flush_req` discards every pending rectangle (including ones pushed after the pulse), leaves `flush_busy` low and clears the flag. Later pushes are then flushed normally.
- R10: A `flush_req` that arrives while `flush_busy` is high is ignored and does not consume a pending invalidate. A `flush_req` on an empty queue leaves `flush_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Store the rectangle on the push fields this cycle |
| push_x | input | 16 | Left edge, signed |
| push_y | input | 16 | Top edge, signed |
| push_w | input | 16 | Width, signed |
| push_h | input | 16 | Height, signed |
| invalidate | input | 1 | Mark all pending rectangles as stale |
| flush_req | input | 1 | Start draining the queue |
| surf_w | input | 16 | Current surface width, unsigned |
| surf_h | input | 16 | Current surface height, unsigned |
| out_valid | output | 1 | A rectangle is presented |
| out_ready | input | 1 | Consumer accepts the presented rectangle |
| out_x | output | 16 | Presented left edge |
| out_y | output | 16 | Presented top edge |
| out_w | output | 16 | Presented width |
| out_h | output | 16 | Presented height |
| flush_busy | output | 1 | A flush is in progress |

## Verification
The bench pushes DEPTH+2 rectangles and expects only the two newest back. A design with a full flag or a stalling push would return the oldest entries or nothing. Rectangles are driven one unit on each side of every limit: negative values, the fixed maxima and the exact surface edge. An off-by-one comparison then turns a legal edge rectangle into a full-surface update, or lets an illegal one through unchanged.

The bench also sends a second flush request while a flush is running, with an invalidate pending. A design that restarts on that request would drop the remaining entry. Separate cases cover pushes during a flush and back-pressure on the output, where a design that ends the flush early or moves its read position would lose or repeat a rectangle.

// File: rtl/damage_rect_queue.sv
module damage_rect_queue #(
  parameter int DEPTH = 512,
  parameter int CW    = 16,
  parameter int MAX_W = 2368,
  parameter int MAX_H = 1770
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [CW-1:0] push_x,
  input  logic [CW-1:0] push_y,
  input  logic [CW-1:0] push_w,
  input  logic [CW-1:0] push_h,
  input  logic          invalidate,
  input  logic          flush_req,
  input  logic [CW-1:0] surf_w,
  input  logic [CW-1:0] surf_h,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_x,
  output logic [CW-1:0] out_y,
  output logic [CW-1:0] out_w,
  output logic [CW-1:0] out_h,
  output logic          flush_busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = CW + 2;
  localparam logic signed [EW-1:0] LIM_W = EW'(MAX_W);
  localparam logic signed [EW-1:0] LIM_H = EW'(MAX_H);

  logic [4*CW-1:0] mem [DEPTH];
  logic [AW-1:0]   wr_idx, rd_idx;
  logic            busy, inval_flag;

  wire empty     = (rd_idx == wr_idx);
  wire start     = flush_req && !busy;
  wire inval_now = inval_flag || invalidate;
  wire pop       = out_valid && out_ready;

  always_ff @(posedge clk)
    if (push_valid) mem[wr_idx] <= {push_x, push_y, push_w, push_h};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx     <= '0;
      rd_idx     <= '0;
      busy       <= 1'b0;
      inval_flag <= 1'b0;
    end else begin
      if (push_valid) wr_idx <= wr_idx + AW'(1);
      if (start && inval_now)  rd_idx <= wr_idx;
      else if (pop)            rd_idx <= rd_idx + AW'(1);
      if (start && inval_now)  inval_flag <= 1'b0;
      else if (invalidate)     inval_flag <= 1'b1;
      if (start && !inval_now && !empty) busy <= 1'b1;
      else if (busy && empty)            busy <= 1'b0;
    end
  end

  assign out_valid  = busy && !empty;
  assign flush_busy = busy;

  logic [4*CW-1:0] ent;
  assign ent = mem[rd_idx];

  logic signed [EW-1:0] ex, ey, ew, eh, esw, esh;
  assign ex  = EW'($signed(ent[4*CW-1:3*CW]));
  assign ey  = EW'($signed(ent[3*CW-1:2*CW]));
  assign ew  = EW'($signed(ent[2*CW-1:CW]));
  assign eh  = EW'($signed(ent[CW-1:0]));
  assign esw = $signed({2'b00, surf_w});
  assign esh = $signed({2'b00, surf_h});

  wire bad_x = (ex < 0) || (ex > LIM_W) || (ew < 0) || (ew > LIM_W) || (ex + ew > esw);
  wire bad_y = (ey < 0) || (ey > LIM_H) || (eh < 0) || (eh > LIM_H) || (ey + eh > esh);
  wire bad   = bad_x || bad_y;

  assign out_x = bad ? '0     : ent[4*CW-1:3*CW];
  assign out_y = bad ? '0     : ent[3*CW-1:2*CW];
  assign out_w = bad ? surf_w : ent[2*CW-1:CW];
  assign out_h = bad ? surf_h : ent[CW-1:0];

  // R4
  valid_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> flush_busy);

  // R5
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !push_valid) |=> out_valid);

  // R10
  busy_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_busy && !flush_req) |=> !flush_busy);

  // R3
  pop_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (rd_idx == $past(rd_idx) + AW'(1)));

  // R8
  inside_surface_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_x} + {1'b0, out_w} <= {1'b0, surf_w}) &&
                  ({1'b0, out_y} + {1'b0, out_h} <= {1'b0, surf_h}));

  // R9
  inval_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_busy && invalidate) |=> !flush_busy);
endmodule

// File: tb/test_damage_rect_queue.sv
module test_damage_rect_queue;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, invalidate = 0, flush_req = 0, out_ready = 0;
  logic [15:0] push_x = 0, push_y = 0, push_w = 0, push_h = 0;
  logic [15:0] surf_w = 16'd1024, surf_h = 16'd768;
  logic out_valid, flush_busy;
  logic [15:0] out_x, out_y, out_w, out_h;
  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  damage_rect_queue i_damage_rect_queue (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
    .push_x(push_x), .push_y(push_y), .push_w(push_w), .push_h(push_h),
    .invalidate(invalidate), .flush_req(flush_req),
    .surf_w(surf_w), .surf_h(surf_h), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_w(out_w), .out_h(out_h), .flush_busy(flush_busy));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk_bit(string tag, logic got, logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic push(int x, int y, int w, int h);
    @(negedge clk);
    push_valid = 1; push_x = 16'(x); push_y = 16'(y); push_w = 16'(w); push_h = 16'(h);
    @(posedge clk);
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic flush();
    @(negedge clk); flush_req = 1;
    @(posedge clk);
    @(negedge clk); flush_req = 0;
  endtask

  task automatic pop_expect(string tag, int x, int y, int w, int h);
    int k = 0;
    while (!out_valid && k < 20) begin @(negedge clk); k++; end
    n_tests++;
    if (!out_valid || out_x !== 16'(x) || out_y !== 16'(y) || out_w !== 16'(w) || out_h !== 16'(h)) begin
      n_fail++;
      $display("FAIL %s: got v=%b (%0d,%0d,%0d,%0d) expected (%0d,%0d,%0d,%0d)", tag, out_valid,
               $signed(out_x), $signed(out_y), $signed(out_w), $signed(out_h), x, y, w, h);
    end
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic expect_idle(string tag);
    @(posedge clk); @(negedge clk);
    chk_bit({tag, " busy"}, flush_busy, 1'b0);
    chk_bit({tag, " valid"}, out_valid, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_bit("R1 busy after reset", flush_busy, 1'b0);
    chk_bit("R1 valid after reset", out_valid, 1'b0);
  endtask

  task automatic t_order();
    push(10, 20, 30, 40);
    push(1, 2, 3, 4);
    push(0, 0, 1024, 768);
    flush();
    chk_bit("R3 busy after flush", flush_busy, 1'b1);
    pop_expect("R3 first", 10, 20, 30, 40);
    pop_expect("R3 second", 1, 2, 3, 4);
    pop_expect("R7 full-size edge accepted", 0, 0, 1024, 768);
    chk_bit("R4 busy one cycle after last pop", flush_busy, 1'b1);
    expect_idle("R4 end of flush");
  endtask

  task automatic t_bounds_x();
    push(-1, 0, 10, 10);
    push(1000, 0, 24, 10);
    push(1000, 0, 25, 10);
    push(5, 0, -3, 10);
    flush();
    pop_expect("R6 negative x", 0, 0, 1024, 768);
    pop_expect("R6 x+w at edge", 1000, 0, 24, 10);
    pop_expect("R6 x+w past edge", 0, 0, 1024, 768);
    pop_expect("R8 negative w fallback", 0, 0, 1024, 768);
    expect_idle("R6 done");
  endtask

  task automatic t_limits();
    surf_w = 16'd3000; surf_h = 16'd2000;
    push(2368, 0, 0, 1);
    push(2369, 0, 0, 1);
    push(0, 0, 2369, 1);
    push(0, 1770, 1, 0);
    push(0, 1771, 1, 0);
    push(0, 0, 1, 1771);
    push(0, -2, 1, 1);
    flush();
    pop_expect("R6 x at max", 2368, 0, 0, 1);
    pop_expect("R6 x above max", 0, 0, 3000, 2000);
    pop_expect("R6 w above max", 0, 0, 3000, 2000);
    pop_expect("R7 y at max", 0, 1770, 1, 0);
    pop_expect("R7 y above max", 0, 0, 3000, 2000);
    pop_expect("R7 h above max", 0, 0, 3000, 2000);
    pop_expect("R7 negative y", 0, 0, 3000, 2000);
    expect_idle("R7 done");
    surf_w = 16'd1024; surf_h = 16'd768;
    push(0, 700, 5, 69);
    flush();
    pop_expect("R7 y+h past surface", 0, 0, 1024, 768);
    expect_idle("R7 surface");
  endtask

  task automatic t_backpressure();
    push(7, 8, 9, 10);
    flush();
    repeat (3) @(negedge clk);
    chk_bit("R5 valid held", out_valid, 1'b1);
    n_tests++;
    if (out_x !== 16'd7 || out_w !== 16'd9) begin
      n_fail++;
      $display("FAIL R5 data held: got x=%0d w=%0d expected x=7 w=9", out_x, out_w);
    end
    pop_expect("R5 after stall", 7, 8, 9, 10);
    expect_idle("R5 done");
  endtask

  task automatic t_push_in_flush();
    push(1, 1, 1, 1);
    push(2, 2, 2, 2);
    flush();
    pop_expect("R4 a", 1, 1, 1, 1);
    push(3, 3, 3, 3);
    pop_expect("R4 b", 2, 2, 2, 2);
    pop_expect("R4 pushed during flush", 3, 3, 3, 3);
    expect_idle("R4 drained");
  endtask

  task automatic t_invalidate();
    push(4, 4, 4, 4);
    push(5, 5, 5, 5);
    @(negedge clk); invalidate = 1; @(posedge clk); @(negedge clk); invalidate = 0;
    push(6, 6, 6, 6);
    flush();
    chk_bit("R9 busy stays low", flush_busy, 1'b0);
    chk_bit("R9 nothing presented", out_valid, 1'b0);
    push(9, 9, 9, 9);
    flush();
    pop_expect("R9 later push flushed", 9, 9, 9, 9);
    expect_idle("R9 done");
  endtask

  task automatic t_flush_rules();
    flush();
    chk_bit("R10 empty flush", flush_busy, 1'b0);
    push(11, 0, 1, 1);
    push(12, 0, 1, 1);
    flush();
    @(negedge clk); invalidate = 1; @(posedge clk); @(negedge clk); invalidate = 0;
    flush();
    pop_expect("R10 flush while busy ignored a", 11, 0, 1, 1);
    pop_expect("R10 flush while busy ignored b", 12, 0, 1, 1);
    expect_idle("R10 done");
    push(13, 0, 1, 1);
    flush();
    chk_bit("R10 pending invalidate kept", flush_busy, 1'b0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 514; i++) begin
      @(negedge clk);
      push_valid = 1; push_x = 16'(i & 511); push_y = 16'd1; push_w = 16'd1; push_h = 16'd1;
    end
    @(negedge clk); push_valid = 0;
    flush();
    pop_expect("R2 overwrite newest-1", 0, 1, 1, 1);
    pop_expect("R2 overwrite newest", 1, 1, 1, 1);
    expect_idle("R2 only two left");
  endtask

  initial begin
    t_reset();
    t_order();
    t_bounds_x();
    t_limits();
    t_backpressure();
    t_push_in_flush();
    t_invalidate();
    t_flush_rules();
    t_overflow();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule